// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a 256-byte serial memory on a two-wire open-drain bus. It oversamples the SCL and SDA lines with the system clock. It finds start and stop conditions and compares each address byte against its own identity. That identity is a fixed `1010` type code followed by three strap pins. The block acknowledges the bytes it accepts, keeps a word pointer, and serves both writes and reads. The storage array is an ordinary register array inside the block.

Writes collect in a four-byte page buffer. They are committed to the array only when the master ends the transfer with a stop. After such a stop the block enters a timed busy period and takes no part in bus traffic. The commit happens when that period expires. Reads shift out bytes from the word pointer, most significant bit first, and continue until the master declines to acknowledge.

Top module: `ee2w_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins an address byte. The slave pulls SDA low during the ninth clock only when bits 7..4 of that byte are `1010` and bits 3..1 equal `strap_i[2:0]`, with bit 3 taken from `strap_i[2]`. On any other address it stays silent until the next start.
- R2: Bit 0 of a matching address byte picks the operation: 0 for a write, 1 for a read.
- R3: In a write, the slave acknowledges the word-address byte and every data byte after it.
- R4: Data reaches the array only when a stop (SDA rising while SCL is high) ends the write. A repeated start before the stop throws away the bytes buffered so far.
- R5: Data bytes fill a 4-byte page. The low two pointer bits advance and wrap inside the page, and the upper six bits stay fixed. A byte that lands on a lane already written replaces the earlier byte.
- R6: A stop that follows at least one accepted data byte raises `busy_o` for exactly `WR_CYCLES` system clocks. A stop after only a word address raises no busy period.
- R7: While `busy_o` is high the slave never drives SDA and acknowledges nothing.
- R8: A read sends the byte at the pointer MSB first and then increments the pointer, wrapping from 0xFF to 0x00. The pointer is set by a word address, and after a page write it rests on the next lane in that page.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start.
- R10: After reset, SDA is released, `busy_o` is low and every array byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| strap_i | input | 3 | Device-select strap levels |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_o | output | 1 | Internal write period in progress |

## Verification
Several properties are checked on every cycle. SDA drive only changes while the synchronised SCL is low, or directly after a start or stop. A busy period only ever begins on a detected stop. The pointer stays frozen while busy. A commit never happens with an empty page buffer. The bit counter never exceeds eight.

The bench scenarios cover everything that needs whole transactions. These are the 128-way address match, byte and page writes with lane wrap and overwrite, and discard on a repeated start. They also include the exact busy length, silence during busy, and sequential reads across the 0xFF wrap, checked against a 256-byte model.

// File: rtl/ee2w_pkg.sv
// Shared types for the two-wire EEPROM slave.
// Assumes: one byte per bus transfer, page size a power of two.
package ee2w_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } bus_state_t;

endpackage

// File: rtl/ee2w_line_sync.sv
// Synchronises SCL/SDA into the system clock domain and flags SCL edges,
// start (SDA fall while SCL high) and stop (SDA rise while SCL high).
// Assumes: the system clock is several times faster than SCL; idle lines are high.
module ee2w_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Purpose: metastability pipeline plus one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Purpose: decode edges and bus conditions from current and previous samples.
    always_comb begin
        scl_lvl_o  = scl_pipe[STAGES-1];
        sda_lvl_o  = sda_pipe[STAGES-1];
        scl_rise_o = scl_lvl_o & ~scl_q;
        scl_fall_o = ~scl_lvl_o & scl_q;
        start_o    = scl_lvl_o & scl_q & sda_q & ~sda_lvl_o;
        stop_o     = scl_lvl_o & scl_q & ~sda_q & sda_lvl_o;
    end

endmodule

// File: rtl/ee2w_page_buf.sv
// Holds the bytes of one page write until the internal write commits them.
// Assumes: clear and commit both empty the buffer; commit is only raised with data held.
module ee2w_page_buf #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 2,
    localparam int PAGE  = 1 << PAGE_W,
    localparam int BASE_W = ADDR_W - PAGE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    commit_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [7:0]              wr_data_i,
    output logic [PAGE-1:0][7:0]    lanes_o,
    output logic [PAGE-1:0]         mask_o,
    output logic [BASE_W-1:0]       base_o
);

    logic [PAGE-1:0][7:0] lanes_q;
    logic [PAGE-1:0]      mask_q;
    logic [BASE_W-1:0]    base_q;

    // Purpose: capture data bytes per lane; later bytes overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_q <= '0;
            mask_q  <= '0;
            base_q  <= '0;
        end else if (clear_i || commit_i) begin
            mask_q  <= '0;
        end else if (wr_en_i) begin
            lanes_q[wr_addr_i[PAGE_W-1:0]] <= wr_data_i;
            mask_q[wr_addr_i[PAGE_W-1:0]]  <= 1'b1;
            base_q                         <= wr_addr_i[ADDR_W-1:PAGE_W];
        end
    end

    assign lanes_o = lanes_q;
    assign mask_o  = mask_q;
    assign base_o  = base_q;

    // R4: the array is only written from a buffer that holds data.
    p_commit_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (mask_q != '0));

endmodule

// File: rtl/ee2w_mem_array.sv
// Byte-wide storage array with an asynchronous read port and a page-wide
// masked write port used by the commit of the internal write cycle.
// Assumes: reset clears every byte.
module ee2w_mem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 2,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PAGE  = 1 << PAGE_W,
    localparam int BASE_W = ADDR_W - PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic [BASE_W-1:0]    base_i,
    input  logic [PAGE-1:0][7:0] lanes_i,
    input  logic [PAGE-1:0]      mask_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [7:0]           rd_data_o
);

    logic [7:0] mem [DEPTH];

    // Purpose: clear on reset, write the masked lanes of one page on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit_i) begin
            for (int l = 0; l < PAGE; l++) begin
                if (mask_i[l]) mem[{base_i, PAGE_W'(l)}] <= lanes_i[l];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/ee2w_slave.sv
// Two-wire EEPROM slave: address match, write pointer, page writes committed
// after a stop and a timed busy period, sequential reads.
// Assumes: SCL is never stretched; the bus only sees open-drain drivers;
// ADDR_W is at most 8 so one word-address byte reaches the whole array.
module ee2w_slave #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 2,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2,
    localparam int PAGE   = 1 << PAGE_W,
    localparam int BASE_W = ADDR_W - PAGE_W,
    localparam int CNT_W  = $clog2(WR_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o,
    output logic       busy_o
);
    import ee2w_pkg::*;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t        state;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_sr;
    logic [7:0]        tx_sr;
    logic [ADDR_W-1:0] ptr_q;
    logic              rw_q;
    logic              mack_q;
    logic [CNT_W-1:0]  wr_cnt;

    logic                 buf_wr;
    logic                 buf_clear;
    logic                 commit;
    logic [PAGE-1:0][7:0] lanes;
    logic [PAGE-1:0]      mask;
    logic [BASE_W-1:0]    base;
    logic [7:0]           rd_data;

    ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    ee2w_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (buf_clear),
        .commit_i  (commit),
        .wr_en_i   (buf_wr),
        .wr_addr_i (ptr_q),
        .wr_data_i (rx_sr),
        .lanes_o   (lanes),
        .mask_o    (mask),
        .base_o    (base)
    );

    ee2w_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .base_i    (base),
        .lanes_i   (lanes),
        .mask_i    (mask),
        .rd_addr_i (ptr_q),
        .rd_data_o (rd_data)
    );

    // Purpose: strobes toward the page buffer and the array.
    always_comb begin
        busy_o    = (state == ST_BUSY);
        commit    = busy_o && (wr_cnt == '0);
        buf_clear = start_det && !busy_o;
        buf_wr    = (state == ST_WDATA) && scl_fall && (bit_cnt == 4'd8);
    end

    // Purpose: open-drain drive during acknowledge slots and zero bits of read data.
    always_comb begin
        sda_oe_o = (state == ST_DEV_ACK) || (state == ST_WADDR_ACK) ||
                   (state == ST_WDATA_ACK) || ((state == ST_RDATA) && !tx_sr[7]);
    end

    // Purpose: bus protocol sequencing, pointer handling and busy timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            wr_cnt  <= '0;
        end else if (state == ST_BUSY) begin
            if (wr_cnt == '0) state <= ST_IDLE;
            else              wr_cnt <= wr_cnt - 1'b1;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
        end else if (stop_det) begin
            if (mask != '0) begin
                state  <= ST_BUSY;
                wr_cnt <= CNT_W'(WR_CYCLES - 1);
            end else begin
                state  <= ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sr   <= {rx_sr[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (state == ST_DEV) begin
                            if (rx_sr[7:1] == {DEV_TYPE, strap_i}) begin
                                rw_q  <= rx_sr[0];
                                state <= ST_DEV_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_WADDR) begin
                            ptr_q <= rx_sr[ADDR_W-1:0];
                            state <= ST_WADDR_ACK;
                        end else begin
                            ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx_sr <= rd_data;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            bit_cnt <= '0;
                            ptr_q   <= ptr_q + 1'b1;
                            state   <= ST_RACK;
                        end else begin
                            tx_sr   <= {tx_sr[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_sr <= rd_data;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: a busy period is entered only on a detected stop.
    p_busy_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det));

    // R7: bus traffic cannot move the pointer while busy.
    p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ptr_q));

    // R1: SDA drive changes only with SCL low, or right after start/stop.
    p_sda_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_lvl || $past(start_det || stop_det)));

    // R3: a byte never holds more than eight received bits.
    p_bit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

endmodule

// File: tb/ee2w_slave_tb.sv
module ee2w_slave_tb;

    localparam int WR_CYCLES = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam int T = 6;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic busy;
    logic sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int busy_cnt = 0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    ee2w_slave #(.WR_CYCLES(WR_CYCLES)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .sda_oe_o (sda_oe),
        .busy_o   (busy)
    );

    always @(negedge clk) if (busy) busy_cnt = busy_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b0; tick(T);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b1; tick(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(T);
            scl_m = 1'b1; tick(T);
            scl_m = 1'b0; tick(T);
        end
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(HALF);
        ack = ~sda_line; tick(T - HALF);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic recv_byte(input logic do_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(T);
            scl_m = 1'b1; tick(HALF);
            b[i] = sda_line; tick(T - HALF);
            scl_m = 1'b0;
        end
        tick(HALF);
        sda_m = ~do_ack; tick(T - HALF);
        scl_m = 1'b1; tick(T);
        scl_m = 1'b0; tick(T);
        sda_m = 1'b1;
    endtask

    task automatic wait_idle;
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic write_bytes(input logic [7:0] addr, input int n, input logic [7:0] d0);
        logic ack;
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack); check_eq("R3 dev ack", ack, 1);
        send_byte(addr, ack);                   check_eq("R3 word addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = d0 + 8'(k * 37);
            send_byte(d, ack); check_eq("R3 data ack", ack, 1);
            model[{addr[7:2], 2'(addr[1:0] + 2'(k))}] = d;
        end
        busy_cnt = 0;
        bus_stop;
        tick(2);
    endtask

    task automatic read_from(input logic [7:0] addr, input int n);
        logic ack;
        logic [7:0] b;
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        send_byte(addr, ack);
        bus_start;
        send_byte({4'b1010, STRAP, 1'b1}, ack); check_eq("R2 read addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check_eq("R8 read data", b, model[8'(addr + 8'(k))]);
        end
        check_eq("R9 released after nack", sda_oe, 0);
        tick(T);
        check_eq("R9 still released", sda_oe, 0);
        bus_stop;
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;

        tick(5);
        check_eq("R10 sda released in reset", sda_oe, 0);
        check_eq("R10 busy low in reset", busy, 0);
        rst_n = 1'b1;
        tick(5);
        check_eq("R10 busy low after reset", busy, 0);

        // R1 sweep of every 7-bit address with the write bit
        for (int a = 0; a < 128; a++) begin
            logic [6:0] av;
            av = 7'(a);
            bus_start;
            send_byte({av, 1'b0}, ack);
            bus_stop;
            check_eq("R1 address match", ack, int'(av[6:3] == 4'b1010 && av[2:0] == STRAP));
        end
        check_eq("R6 no busy after address-only", busy, 0);

        // R6/R7 byte write, busy length and silence
        write_bytes(8'h35, 1, 8'hA7);
        check_eq("R6 busy after stop", busy, 1);
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        check_eq("R7 no ack while busy", ack, 0);
        bus_stop;
        wait_idle;
        check_eq("R6 busy length", busy_cnt, WR_CYCLES);

        read_from(8'h35, 1);

        // R5 page write with wrap and overwrite (6 bytes from lane 2)
        write_bytes(8'h42, 6, 8'h11);
        wait_idle;
        check_eq("R5 page lane 0", model[8'h40], 8'(8'h11 + 8'(2 * 37)));
        bus_start;
        send_byte({4'b1010, STRAP, 1'b1}, ack); check_eq("R2 current read ack", ack, 1);
        recv_byte(1'b0, b);
        check_eq("R8 pointer after page", b, model[8'h40]);
        bus_stop;
        read_from(8'h3C, 12);

        // R4 repeated start discards buffered data
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        send_byte(8'h80, ack);
        send_byte(8'h5A, ack); check_eq("R3 data ack before rs", ack, 1);
        busy_cnt = 0;
        bus_start;
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        send_byte(8'h81, ack);
        bus_stop;
        tick(WR_CYCLES + 20);
        check_eq("R4 no commit without stop", busy_cnt, 0);
        read_from(8'h80, 2);

        // R8 wrap across the top of the array
        write_bytes(8'hFF, 1, 8'h3C);
        wait_idle;
        write_bytes(8'h00, 1, 8'hC3);
        wait_idle;
        read_from(8'hFE, 4);

        // R8 whole-array sequential read against the model
        read_from(8'h00, 256);

        // R1 read address with wrong strap bits is ignored
        bus_start;
        send_byte({4'b1010, STRAP ^ 3'b111, 1'b1}, ack);
        check_eq("R1 wrong strap ignored", ack, 0);
        tick(T);
        check_eq("R1 no drive after mismatch", sda_oe, 0);
        bus_stop;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R6 watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule